// File: doc/BRIEF.md
# Dual-Byte Bidirectional Latched Bus Transceiver

This block joins two 16-bit buses, called side A and side B, through a pair of independent byte-wide lanes. Each byte lane carries data in both directions. Each direction has its own level-sensitive holding latch and its own output stage. Three active-low controls govern each direction: a chip select, a latch gate and a drive enable. A byte lane therefore has six controls, and the two lanes share none of them.

Within one direction, the latch follows its input while both the chip select and the latch gate are low. It freezes as soon as either of them rises. The output drives the frozen or followed value only while both the chip select and the drive enable are low. Each pin is split into separate input, output-value and output-enable signals, so that pad logic can build the tristate buffer. A per-lane flag reports when both directions of that lane are set to drive their buses at the same time.

The design has no clock, no reset and no state machine. Its only state is held in the four latches. A latch's contents are undefined until the latch has been opened once.

Top module: `bus_xcvr16`

## Requirements
- R1: The two byte lanes (bits 7:0 are lane 0, bits 15:8 are lane 1) are independent. Controls and data of one lane never change the outputs of the other lane.
- R2: With the A-to-B chip select and latch gate both low, the A-to-B latch is open. While the B side is driven, `b_out` of that lane equals the current `a_in`.
- R3: When the A-to-B latch gate rises while the chip select is low, the latch keeps the `a_in` value present before the rise. Later changes of `a_in` do not reach `b_out`.
- R4: With the A-to-B chip select high, the latch keeps its contents whatever the latch gate and `a_in` do.
- R5: The `b_oe` bits of a lane are all 1 exactly when that lane's A-to-B chip select and drive enable are both low. Otherwise they are all 0.
- R6: When `b_oe` of a lane is 0, `b_out` of that lane is all zeros.
- R7: When the B side of a lane is driven while the latch is closed, `b_out` shows the held latch value.
- R8: The B-to-A direction mirrors R2 to R7. It uses `ceba_n`, `leba_n` and `oeba_n`, `b_in` as its source, `a_out` and `a_oe` as its outputs, and a separate latch.
- R9: `dir_conflict[g]` is 1 exactly when both `a_oe` and `b_oe` of lane g are asserted.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| a_in | input | 16 | Value sensed on the A-side pins |
| b_in | input | 16 | Value sensed on the B-side pins |
| ceab_n | input | 2 | A-to-B chip select per lane, active low |
| leab_n | input | 2 | A-to-B latch gate per lane, active low |
| oeab_n | input | 2 | A-to-B drive enable per lane, active low |
| ceba_n | input | 2 | B-to-A chip select per lane, active low |
| leba_n | input | 2 | B-to-A latch gate per lane, active low |
| oeba_n | input | 2 | B-to-A drive enable per lane, active low |
| a_out | output | 16 | Value to drive on the A-side pins |
| a_oe | output | 16 | Per-bit drive enable for the A-side pins |
| b_out | output | 16 | Value to drive on the B-side pins |
| b_oe | output | 16 | Per-bit drive enable for the B-side pins |
| dir_conflict | output | 2 | Per-lane flag: both directions driving |

## Verification
Some relationships can be judged from the ports at any instant, and the assertions check these continuously. They cover: a lane's enable bits agreeing with each other and with the chip select, outputs reading zero when not driven, an open latch passing its input straight through, and the conflict flag matching the two enable groups. Holding behaviour depends on what happened earlier: the value kept across a latch-gate rise, immunity while the chip select is high, and isolation between lanes. Only the bench's sequences can show these. The bench walks every combination of the six controls of each lane while keeping its own model of the four latches.

// File: rtl/xcvr_pkg.sv
package xcvr_pkg;

    // Active-low control triple for one transfer direction.
    typedef struct packed {
        logic sel_n;   // chip select
        logic gate_n;  // latch gate
        logic drv_n;   // drive enable
    } dir_ctl_t;

endpackage

// File: rtl/xcvr_latch.sv
module xcvr_latch #(
    parameter int W = 8
) (
    input  logic         open_i,
    input  logic [W-1:0] d_i,
    output logic [W-1:0] q_o
);

    always_latch begin
        if (open_i) begin
            q_o <= d_i;
        end
    end

endmodule

// File: rtl/xcvr_dir.sv
module xcvr_dir
    import xcvr_pkg::*;
#(
    parameter int W = 8
) (
    input  dir_ctl_t     ctl_i,
    input  logic [W-1:0] src_i,
    output logic [W-1:0] val_o,
    output logic [W-1:0] oe_o,
    output logic         drive_o
);

    logic         open_w;
    logic [W-1:0] held_w;

    // Latch follows only while select and gate are both asserted.
    assign open_w  = ~ctl_i.sel_n & ~ctl_i.gate_n;
    // Output drives only while select and drive enable are both asserted.
    assign drive_o = ~ctl_i.sel_n & ~ctl_i.drv_n;

    xcvr_latch #(.W(W)) u_hold (
        .open_i (open_w),
        .d_i    (src_i),
        .q_o    (held_w)
    );

    always_comb begin
        val_o = drive_o ? held_w : '0;
        oe_o  = {W{drive_o}};
    end

endmodule

// File: rtl/xcvr_lane.sv
module xcvr_lane
    import xcvr_pkg::*;
#(
    parameter int W = 8
) (
    input  dir_ctl_t     fwd_ctl_i,
    input  dir_ctl_t     rev_ctl_i,
    input  logic [W-1:0] a_i,
    input  logic [W-1:0] b_i,
    output logic [W-1:0] a_val_o,
    output logic [W-1:0] a_oe_o,
    output logic [W-1:0] b_val_o,
    output logic [W-1:0] b_oe_o,
    output logic         clash_o
);

    logic fwd_drv;
    logic rev_drv;

    xcvr_dir #(.W(W)) u_fwd (
        .ctl_i   (fwd_ctl_i),
        .src_i   (a_i),
        .val_o   (b_val_o),
        .oe_o    (b_oe_o),
        .drive_o (fwd_drv)
    );

    xcvr_dir #(.W(W)) u_rev (
        .ctl_i   (rev_ctl_i),
        .src_i   (b_i),
        .val_o   (a_val_o),
        .oe_o    (a_oe_o),
        .drive_o (rev_drv)
    );

    assign clash_o = fwd_drv & rev_drv;

endmodule

// File: rtl/bus_xcvr16.sv
module bus_xcvr16
    import xcvr_pkg::*;
#(
    parameter int GRP_W   = 8,
    parameter int NUM_GRP = 2,
    localparam int BUS_W  = GRP_W * NUM_GRP
) (
    input  logic [BUS_W-1:0]   a_in,
    input  logic [BUS_W-1:0]   b_in,
    input  logic [NUM_GRP-1:0] ceab_n,
    input  logic [NUM_GRP-1:0] leab_n,
    input  logic [NUM_GRP-1:0] oeab_n,
    input  logic [NUM_GRP-1:0] ceba_n,
    input  logic [NUM_GRP-1:0] leba_n,
    input  logic [NUM_GRP-1:0] oeba_n,
    output logic [BUS_W-1:0]   a_out,
    output logic [BUS_W-1:0]   a_oe,
    output logic [BUS_W-1:0]   b_out,
    output logic [BUS_W-1:0]   b_oe,
    output logic [NUM_GRP-1:0] dir_conflict
);

    for (genvar g = 0; g < NUM_GRP; g++) begin : g_lane
        dir_ctl_t fwd_ctl;
        dir_ctl_t rev_ctl;

        always_comb begin
            fwd_ctl = '{sel_n: ceab_n[g], gate_n: leab_n[g], drv_n: oeab_n[g]};
            rev_ctl = '{sel_n: ceba_n[g], gate_n: leba_n[g], drv_n: oeba_n[g]};
        end

        xcvr_lane #(.W(GRP_W)) u_lane (
            .fwd_ctl_i (fwd_ctl),
            .rev_ctl_i (rev_ctl),
            .a_i       (a_in[g*GRP_W +: GRP_W]),
            .b_i       (b_in[g*GRP_W +: GRP_W]),
            .a_val_o   (a_out[g*GRP_W +: GRP_W]),
            .a_oe_o    (a_oe[g*GRP_W +: GRP_W]),
            .b_val_o   (b_out[g*GRP_W +: GRP_W]),
            .b_oe_o    (b_oe[g*GRP_W +: GRP_W]),
            .clash_o   (dir_conflict[g])
        );
    end

endmodule

// File: rtl/bus_xcvr16_chk.sv
module bus_xcvr16_chk #(
    parameter int GRP_W   = 8,
    parameter int NUM_GRP = 2,
    localparam int BUS_W  = GRP_W * NUM_GRP
) (
    input logic [BUS_W-1:0]   a_in,
    input logic [BUS_W-1:0]   b_in,
    input logic [NUM_GRP-1:0] ceab_n,
    input logic [NUM_GRP-1:0] leab_n,
    input logic [NUM_GRP-1:0] oeab_n,
    input logic [NUM_GRP-1:0] ceba_n,
    input logic [NUM_GRP-1:0] leba_n,
    input logic [NUM_GRP-1:0] oeba_n,
    input logic [BUS_W-1:0]   a_out,
    input logic [BUS_W-1:0]   a_oe,
    input logic [BUS_W-1:0]   b_out,
    input logic [BUS_W-1:0]   b_oe,
    input logic [NUM_GRP-1:0] dir_conflict
);

    always_comb begin
        for (int g = 0; g < NUM_GRP; g++) begin
            // R5: enable bits of a lane move together, and only with the select low
            assert_b_oe_uniform_R5: assert (b_oe[g*GRP_W +: GRP_W] == '0 ||
                                             (b_oe[g*GRP_W +: GRP_W] == '1 && !ceab_n[g]))
                else $error("b_oe lane %0d inconsistent", g);
            // R8: same for the reverse direction
            assert_a_oe_uniform_R8: assert (a_oe[g*GRP_W +: GRP_W] == '0 ||
                                             (a_oe[g*GRP_W +: GRP_W] == '1 && !ceba_n[g]))
                else $error("a_oe lane %0d inconsistent", g);
            // R6: an undriven side reads zero
            assert_idle_zero_R6: assert (b_oe[g*GRP_W] || b_out[g*GRP_W +: GRP_W] == '0)
                else $error("b_out lane %0d nonzero while idle", g);
            // R2: open latch with drive passes input through
            assert_pass_through_R2: assert (ceab_n[g] || leab_n[g] || !b_oe[g*GRP_W] ||
                                            b_out[g*GRP_W +: GRP_W] == a_in[g*GRP_W +: GRP_W])
                else $error("b_out lane %0d not following a_in", g);
            // R8: mirror pass-through
            assert_rev_pass_R8: assert (ceba_n[g] || leba_n[g] || !a_oe[g*GRP_W] ||
                                        a_out[g*GRP_W +: GRP_W] == b_in[g*GRP_W +: GRP_W])
                else $error("a_out lane %0d not following b_in", g);
            // R9: conflict flag agrees with the two enable groups
            assert_conflict_R9: assert (dir_conflict[g] == (a_oe[g*GRP_W] && b_oe[g*GRP_W]))
                else $error("dir_conflict lane %0d wrong", g);
            // R5: drive implies drive enable low
            assert_drive_gate_R5: assert (!b_oe[g*GRP_W] || !oeab_n[g])
                else $error("b_oe lane %0d with drive enable high", g);
        end
    end

endmodule

bind bus_xcvr16 bus_xcvr16_chk #(.GRP_W(GRP_W), .NUM_GRP(NUM_GRP)) u_chk (.*);

// File: tb/bus_xcvr16_test.sv
module bus_xcvr16_test;

    localparam int CLK_PERIOD = 10;
    localparam int GW = 8;
    localparam int NG = 2;
    localparam int BW = GW * NG;

    logic clk = 1'b0;
    always #(CLK_PERIOD/2) clk = ~clk;

    logic [BW-1:0] a_in, b_in, a_out, a_oe, b_out, b_oe;
    logic [NG-1:0] ceab_n, leab_n, oeab_n, ceba_n, leba_n, oeba_n, dir_conflict;

    bus_xcvr16 uut (
        .a_in(a_in), .b_in(b_in),
        .ceab_n(ceab_n), .leab_n(leab_n), .oeab_n(oeab_n),
        .ceba_n(ceba_n), .leba_n(leba_n), .oeba_n(oeba_n),
        .a_out(a_out), .a_oe(a_oe), .b_out(b_out), .b_oe(b_oe),
        .dir_conflict(dir_conflict)
    );

    int checks = 0;
    int errors = 0;
    bit done = 0;

    // bench model of the four latches
    logic [GW-1:0] m_ab [NG];
    logic [GW-1:0] m_ba [NG];

    task automatic chk(input string req, input string what, input logic [31:0] got, input logic [31:0] exp);
        checks++;
        if (got !== exp) begin
            errors++;
            $display("FAIL %s %s got=%h exp=%h at %0t", req, what, got, exp, $time);
        end
    endtask

    task automatic model_update();
        for (int g = 0; g < NG; g++) begin
            if (!ceab_n[g] && !leab_n[g]) m_ab[g] = a_in[g*GW +: GW];
            if (!ceba_n[g] && !leba_n[g]) m_ba[g] = b_in[g*GW +: GW];
        end
    endtask

    task automatic check_all();
        for (int g = 0; g < NG; g++) begin
            logic fd, rd;
            logic [GW-1:0] eb, ea;
            string rb, ra;
            fd = !ceab_n[g] && !oeab_n[g];
            rd = !ceba_n[g] && !oeba_n[g];
            eb = fd ? m_ab[g] : '0;
            ea = rd ? m_ba[g] : '0;
            rb = !fd ? "R6" : (!leab_n[g] ? "R2" : "R7");
            ra = "R8";
            chk("R5", $sformatf("b_oe lane%0d", g), 32'(b_oe[g*GW +: GW]), fd ? 32'hFF : 32'h0);
            chk(rb, $sformatf("b_out lane%0d", g), 32'(b_out[g*GW +: GW]), 32'(eb));
            chk(ra, $sformatf("a_oe lane%0d", g), 32'(a_oe[g*GW +: GW]), rd ? 32'hFF : 32'h0);
            chk(ra, $sformatf("a_out lane%0d", g), 32'(a_out[g*GW +: GW]), 32'(ea));
            chk("R9", $sformatf("conflict lane%0d", g), 32'(dir_conflict[g]), 32'(fd && rd));
        end
    endtask

    initial begin
        #(CLK_PERIOD * 100000);
        if (!done) begin
            errors++;
            $display("FAIL watchdog expired");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        // quiet state: everything deselected
        ceab_n = '1; leab_n = '1; oeab_n = '1;
        ceba_n = '1; leba_n = '1; oeba_n = '1;
        a_in = 16'h0000; b_in = 16'h0000;
        #(CLK_PERIOD);
        chk("R6", "idle b_out", 32'(b_out), 32'h0);
        chk("R5", "idle b_oe", 32'(b_oe), 32'h0);
        chk("R8", "idle a_oe", 32'(a_oe), 32'h0);
        chk("R9", "idle conflict", 32'(dir_conflict), 32'h0);

        // first load of every latch
        a_in = 16'h3C5A; b_in = 16'hA5C3;
        ceab_n = '0; leab_n = '0; ceba_n = '0; leba_n = '0;
        #(CLK_PERIOD/2);
        model_update();
        leab_n = '1; leba_n = '1;
        #(CLK_PERIOD/2);

        // exhaustive walk of both lanes' six controls
        for (int step = 0; step < 64; step++) begin
            for (int g = 0; g < NG; g++) begin
                int c;
                c = (g == 0) ? step : ((step * 5 + 3) % 64);
                ceab_n[g] = c[0]; leab_n[g] = c[1]; oeab_n[g] = c[2];
                ceba_n[g] = c[3]; leba_n[g] = c[4]; oeba_n[g] = c[5];
            end
            #2;
            model_update();
            for (int g = 0; g < NG; g++) begin
                a_in[g*GW +: GW] = GW'((step * 37 + g * 91 + 5) & 8'hFF);
                b_in[g*GW +: GW] = GW'((step * 53 + g * 29 + 11) & 8'hFF);
            end
            #2;
            model_update();
            check_all();
            #(CLK_PERIOD - 4);
        end

        // directed hold tests on lane 0, lane 1 parked driving its held value
        ceab_n = '1; leab_n = '1; oeab_n = '1; ceba_n = '1; leba_n = '1; oeba_n = '1;
        #2;
        a_in = 16'h77AA;
        ceab_n = 2'b11; leab_n = 2'b10; // lane0 open
        ceab_n[0] = 1'b0;
        #2;
        leab_n[0] = 1'b1;               // R3: rising gate with select low
        #2;
        a_in[7:0] = 8'h55;
        ceab_n[1] = 1'b0; oeab_n = 2'b00; // lane1 drives its held value
        #2;
        chk("R3", "held across gate rise", 32'(b_out[7:0]), 32'hAA);
        begin
            logic [7:0] lane1_ref;
            lane1_ref = b_out[15:8];
            // R4: select high, gate toggles, data changes
            ceab_n[0] = 1'b1;
            leab_n[0] = 1'b0; a_in[7:0] = 8'h33; #2;
            leab_n[0] = 1'b1; a_in[7:0] = 8'h99; #2;
            leab_n[0] = 1'b0; #2;
            chk("R4", "undriven while select high", 32'(b_out[7:0]), 32'h0);
            leab_n[0] = 1'b1; #2;
            ceab_n[0] = 1'b0; #2;
            chk("R4", "held while select high", 32'(b_out[7:0]), 32'hAA);
            chk("R1", "lane1 untouched by lane0", 32'(b_out[15:8]), 32'(lane1_ref));
            // R1: reopen lane0 with new data, lane1 stays
            leab_n[0] = 1'b0; a_in[7:0] = 8'hE1; #2;
            chk("R2", "lane0 follows", 32'(b_out[7:0]), 32'hE1);
            chk("R1", "lane1 still untouched", 32'(b_out[15:8]), 32'(lane1_ref));
        end

        done = 1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule